// File: doc/BRIEF.md
# Doubleword Shift and Rotate Unit

This block is the shift and rotate unit of a 64-bit integer datapath. It takes one operand, a 5-bit immediate, a register holding a variable amount, and a 4-bit operation code. From these it returns the operand shifted left, shifted right with zero fill, shifted right with sign fill, or rotated right. The unit is purely combinational, so the result follows its inputs within the same cycle.

The operation code selects both the kind of shift and where the amount comes from. The amount can be the immediate as given (0 to 31), the immediate raised by 32 (32 to 63), or the low six bits of the amount register. A single right-rotating barrel network serves all four kinds. Left shifts reuse it by mirroring the operand on the way in and mirroring the result on the way out. Shifts then clear or sign-fill the bits that wrapped around.

Top module: `bsh_shift_unit`

## Requirements
- R1: Kind code 00 (op[3:2]) is a logical left shift; vacated low bits are 0.
- R2: Kind code 01 is a logical right shift; vacated high bits are 0.
- R3: Kind code 10 is an arithmetic right shift; vacated high bits copy operand bit 63.
- R4: Kind code 11 rotates right by n: result = (x >> n) | (x << (64 - n)).
- R5: Form code 00 (op[1:0]) uses the 5-bit immediate as the amount, 0 to 31.
- R6: Form code 01 uses the immediate plus 32 as the amount, 32 to 63.
- R7: Form code 10 uses bits [5:0] of the amount register; bits [63:6] of that register have no effect on the result.
- R8: An effective amount of 0 returns the operand unchanged for every kind, rotate included.
- R9: Form code 11 is unused; for any kind the result is all zeros.
- R10: The result is a combinational function of the inputs and is valid in the same cycle the inputs are applied. With all inputs zero, the result is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 64 | Operand to shift or rotate |
| imm_i | input | 5 | Immediate amount field |
| amt_reg_i | input | 64 | Register holding a variable amount (low 6 bits used) |
| op_i | input | 4 | Operation code: [3:2] kind, [1:0] amount form |
| res_o | output | 64 | Shifted or rotated result |

## Verification
The bench builds the unit with its default width of 64. At that width the immediate is 5 bits and the amount is 6 bits. Every combination of the 16 operation codes and the 32 immediates can therefore be driven exhaustively against several operands, and the variable form can be swept through all 64 amounts. At this width the sign bit and the 32-crossing of the plus-32 form sit at their real positions. Random upper bits in the amount register show that only the low six bits steer the result.

// File: rtl/bsh_pkg.sv
package bsh_pkg;

  typedef enum logic [1:0] {
    KIND_SLL = 2'b00,
    KIND_SRL = 2'b01,
    KIND_SRA = 2'b10,
    KIND_ROR = 2'b11
  } shift_kind_e;

  typedef enum logic [1:0] {
    FORM_IMM    = 2'b00,
    FORM_IMM_HI = 2'b01,
    FORM_VAR    = 2'b10,
    FORM_NONE   = 2'b11
  } amt_form_e;

  function automatic shift_kind_e op_kind(input logic [3:0] op);
    return shift_kind_e'(op[3:2]);
  endfunction

  function automatic amt_form_e op_form(input logic [3:0] op);
    return amt_form_e'(op[1:0]);
  endfunction

endpackage

// File: rtl/bsh_amount_sel.sv
module bsh_amount_sel
  import bsh_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int AMT_W = $clog2(DATA_W),
  localparam int IMM_W = AMT_W - 1
) (
  input  amt_form_e          form_i,
  input  logic [IMM_W-1:0]   imm_i,
  input  logic [DATA_W-1:0]  amt_reg_i,
  output logic [AMT_W-1:0]   amt_o
);

  localparam logic [DATA_W-1:0] LOW_MASK = DATA_W'((1 << AMT_W) - 1);

  logic [DATA_W-1:0] reg_clipped;

  assign reg_clipped = amt_reg_i & LOW_MASK;

  always_comb begin
    unique case (form_i)
      FORM_IMM:    amt_o = {1'b0, imm_i};
      FORM_IMM_HI: amt_o = {1'b1, imm_i};
      FORM_VAR:    amt_o = AMT_W'(reg_clipped);
      default:     amt_o = '0;
    endcase
  end

  always_comb begin
    if (form_i == FORM_IMM_HI)
      assert_hi_form_half_R6: assert (amt_o >= AMT_W'(DATA_W / 2))
        else $error("plus-half form produced amount below half width");
    if (form_i == FORM_IMM)
      assert_imm_form_low_R5: assert (amt_o < AMT_W'(DATA_W / 2))
        else $error("immediate form produced amount at or above half width");
  end

endmodule

// File: rtl/bsh_rotator.sv
module bsh_rotator #(
  parameter int DATA_W = 64,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [AMT_W-1:0]  amt_i,
  output logic [DATA_W-1:0] rot_o
);

  logic [DATA_W-1:0] stage [AMT_W+1];

  assign stage[0] = data_i;

  for (genvar s = 0; s < AMT_W; s++) begin : g_stage
    localparam int SH = 1 << s;
    assign stage[s+1] = amt_i[s] ? {stage[s][SH-1:0], stage[s][DATA_W-1:SH]}
                                 : stage[s];
  end

  assign rot_o = stage[AMT_W];

  always_comb begin
    assert_rot_keeps_ones_R4: assert ($countones(rot_o) == $countones(data_i))
      else $error("rotation changed the number of set bits");
    assert_rot_lsb_source_R4: assert (rot_o[0] == data_i[amt_i])
      else $error("rotation placed the wrong bit at position zero");
  end

endmodule

// File: rtl/bsh_mask_gen.sv
module bsh_mask_gen #(
  parameter int DATA_W = 64,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  logic [AMT_W-1:0]  amt_i,
  output logic [DATA_W-1:0] keep_o
);

  always_comb begin
    for (int b = 0; b < DATA_W; b++)
      keep_o[b] = (b < DATA_W - int'(amt_i));
  end

  always_comb begin
    assert_keep_count_R2: assert ($countones(keep_o) == DATA_W - int'(amt_i))
      else $error("keep mask width does not match amount");
    assert_keep_lsb_R8: assert (keep_o[0])
      else $error("keep mask lost bit zero");
  end

endmodule

// File: rtl/bsh_shift_unit.sv
module bsh_shift_unit
  import bsh_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int AMT_W = $clog2(DATA_W),
  localparam int IMM_W = AMT_W - 1
) (
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [DATA_W-1:0] amt_reg_i,
  input  logic [3:0]        op_i,
  output logic [DATA_W-1:0] res_o
);

  function automatic logic [DATA_W-1:0] mirror(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    for (int b = 0; b < DATA_W; b++) r[b] = v[DATA_W-1-b];
    return r;
  endfunction

  shift_kind_e       kind;
  amt_form_e         form;
  logic [AMT_W-1:0]  eff_amt;
  logic              go_left;
  logic              sign_fill;
  logic [DATA_W-1:0] pre_rot;
  logic [DATA_W-1:0] rot;
  logic [DATA_W-1:0] keep;
  logic [DATA_W-1:0] shifted;

  assign kind      = op_kind(op_i);
  assign form      = op_form(op_i);
  assign go_left   = (kind == KIND_SLL);
  assign sign_fill = (kind == KIND_SRA) && opnd_i[DATA_W-1];
  assign pre_rot   = go_left ? mirror(opnd_i) : opnd_i;

  bsh_amount_sel #(.DATA_W(DATA_W)) u_amt (
    .form_i    (form),
    .imm_i     (imm_i),
    .amt_reg_i (amt_reg_i),
    .amt_o     (eff_amt)
  );

  bsh_rotator #(.DATA_W(DATA_W)) u_rot (
    .data_i (pre_rot),
    .amt_i  (eff_amt),
    .rot_o  (rot)
  );

  bsh_mask_gen #(.DATA_W(DATA_W)) u_mask (
    .amt_i  (eff_amt),
    .keep_o (keep)
  );

  assign shifted = (rot & keep) | (sign_fill ? ~keep : '0);

  always_comb begin
    if (form == FORM_NONE)        res_o = '0;
    else if (kind == KIND_ROR)    res_o = rot;
    else if (go_left)             res_o = mirror(shifted);
    else                          res_o = shifted;
  end

  logic [DATA_W-1:0] low_fill;
  assign low_fill = ~({DATA_W{1'b1}} << eff_amt);

  always_comb begin
    if (form != FORM_NONE && eff_amt == '0)
      assert_zero_amt_identity_R8: assert (res_o == opnd_i)
        else $error("zero amount altered the operand");
    if (form != FORM_NONE && kind == KIND_SLL)
      assert_sll_low_clear_R1: assert ((res_o & low_fill) == '0)
        else $error("left shift left vacated low bits set");
    if (form != FORM_NONE && kind == KIND_SRA)
      assert_sra_sign_kept_R3: assert (res_o[DATA_W-1] == opnd_i[DATA_W-1])
        else $error("arithmetic shift lost the sign");
    if (form == FORM_NONE)
      assert_unused_form_zero_R9: assert (res_o == '0)
        else $error("unused form produced non-zero result");
  end

endmodule

// File: tb/test_bsh_shift_unit.sv
module test_bsh_shift_unit;

  localparam int W = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] opnd = '0;
  logic [4:0]  imm = '0;
  logic [63:0] areg = '0;
  logic [3:0]  op = '0;
  logic [63:0] res;

  typedef struct {
    logic [63:0] exp;
    logic [3:0]  op;
    int          amt;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bsh_shift_unit i_bsh_shift_unit (
    .opnd_i    (opnd),
    .imm_i     (imm),
    .amt_reg_i (areg),
    .op_i      (op),
    .res_o     (res)
  );

  // Reference: bit-by-bit selection, written from the requirements.
  function automatic int eff_amount(logic [3:0] o, logic [4:0] i, logic [63:0] r);
    case (o[1:0])
      2'b00:   return int'(i);
      2'b01:   return int'(i) + 32;
      2'b10:   return int'(r % 64);
      default: return -1;
    endcase
  endfunction

  function automatic logic [63:0] model(logic [63:0] x, logic [3:0] o, int n);
    logic [63:0] y;
    if (n < 0) return '0;
    for (int i = 0; i < 64; i++) begin
      case (o[3:2])
        2'b00: y[i] = (i >= n) ? x[i-n] : 1'b0;
        2'b01: y[i] = (i + n < 64) ? x[i+n] : 1'b0;
        2'b10: y[i] = (i + n < 64) ? x[i+n] : x[63];
        default: y[i] = x[(i + n) % 64];
      endcase
    end
    return y;
  endfunction

  function automatic string tag_of(logic [3:0] o, int n);
    string k, f;
    if (o[1:0] == 2'b11) return "R9";
    case (o[3:2])
      2'b00: k = "R1";
      2'b01: k = "R2";
      2'b10: k = "R3";
      default: k = "R4";
    endcase
    case (o[1:0])
      2'b00: f = "R5";
      2'b01: f = "R6";
      default: f = "R7";
    endcase
    if (n == 0) return {k, "/", f, "/R8"};
    return {k, "/", f};
  endfunction

  task automatic drive(logic [63:0] x, logic [3:0] o, logic [4:0] i, logic [63:0] r);
    item_t it;
    int n;
    @(posedge clk);
    #1;
    opnd = x; op = o; imm = i; areg = r;
    n = eff_amount(o, i, r);
    it.exp = model(x, o, n);
    it.op  = o;
    it.amt = n;
    it.tag = tag_of(o, n);
    q.push_back(it);
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  // Monitor: result sampled one ns after the inputs, within the same cycle (R10).
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (res !== it.exp) begin
          errors++;
          $display("FAIL %s op=%h amt=%0d got=%h exp=%h", it.tag, it.op, it.amt, res, it.exp);
        end
      end
    end
  end

  initial begin
    logic [63:0] pats [4];
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state, all inputs zero gives zero in the same cycle.
    checks++;
    if (res !== 64'h0) begin
      errors++;
      $display("FAIL R10 reset state got=%h exp=%h", res, 64'h0);
    end
    rst_n = 1'b1;

    pats[0] = 64'h8000_0000_0000_0001;
    pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[2] = rnd64() | 64'h8000_0000_0000_0000;
    pats[3] = rnd64() & 64'h7FFF_FFFF_FFFF_FFFF;

    // Every opcode with every immediate: R1..R6, R8, R9.
    for (int o = 0; o < 16; o++)
      for (int i = 0; i < 32; i++)
        for (int p = 0; p < 4; p++)
          drive(pats[p], 4'(o), 5'(i), rnd64());

    // Variable form, all 64 amounts, random upper bits in the register (R7).
    for (int k = 0; k < 4; k++)
      for (int a = 0; a < 64; a++) begin
        drive(rnd64(), {2'(k), 2'b10}, 5'($urandom()), {rnd64() & ~64'h3F} | 64'(a));
        drive(pats[2], {2'(k), 2'b10}, 5'd0, {58'h0, 6'(a)});
        drive(pats[2], {2'(k), 2'b10}, 5'd31, {58'h3FF_FFFF_FFFF_FFFF, 6'(a)});
      end

    // Random mixed stimulus.
    for (int t = 0; t < 500; t++)
      drive(rnd64(), 4'($urandom()), 5'($urandom()), rnd64());

    repeat (3) @(posedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired, pending items=%0d", q.size());
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule